// File: doc/BRIEF.md
# LED Matrix Scan PWM Controller

This block time-multiplexes a matrix of light-emitting diodes arranged as four columns by three rows. At any moment it closes at most one column switch, and for that column it drives the three row current-sink enables with pulse-width modulation. Every one of the twelve LEDs has its own enable bit and its own 8-bit brightness level, both taken from a plain parallel register input. A global enable starts and stops the whole matrix. While the matrix is off it stays dark and restarts at the first column.

Timing is counted in base ticks. A select input chooses the tick source. The default source gives one tick on every cycle of the block clock, which is the internal oscillator. The other source gives one tick per rising edge of an external clock, after that clock has been synchronised. A direction input decides whether the shared clock pin is driven. When it is driven, the pin carries a toggle at half the tick rate. A 3-bit full-scale current code is passed straight through to the analog regulators.

Columns are scanned in a fixed order. Each column gets one 256-tick PWM slot, and a short all-dark gap separates consecutive slots. Register values are copied into a shadow bank only at frame boundaries, so a frame is never drawn with a mix of old and new settings.

Top module: `led_matrix_scan`

## Requirements
- R1: While `matrix_en_i` is low every column and row output is 0 in the same cycle, and the next enable starts the scan at column A with its blanking gap.
- R2: Columns are driven one-hot in the order A, B, C, D, then A again, with column A on `col_sel_o[0]` through column D on `col_sel_o[3]`; each column stays selected for exactly 256 ticks.
- R3: During tick c (0..255) of a column's slot, row r is 1 if and only if that LED's enable bit is set and c is less than its level; level 0 never lights, level 255 lights for 255 of the 256 ticks. Level of column k, row r sits at `led_level_i[(3k+r)*8 +: 8]`.
- R4: Before each column slot, including the first one after enable, all column and row outputs are 0 for 2 ticks.
- R5: Enable bits are packed two columns per byte: byte j of `led_on_i` serves columns 2j and 2j+1, bits 2:0 of the byte are rows 1–3 of column 2j, bits 6:4 are rows 1–3 of column 2j+1, and bits 3 and 7 have no effect.
- R6: Changes to `led_on_i` or `led_level_i` made during a frame have no effect on the outputs until the next frame starts at column A.
- R7: With `clk_src_ext_i` low every clock cycle is a tick. With it high, each rising edge of `ext_clk_i` is one tick (after a 2-stage synchroniser), and a static external clock freezes the scan.
- R8: `clk_pin_oe_o` is 1 only when the pin direction input is 1 and the internal source is selected, and `clk_pin_o` toggles once per tick.
- R9: `imax_o` equals `imax_i` at all times.
- R10: A row output is never 1 while no column is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (internal oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External base clock from the clock pin |
| clk_src_ext_i | input | 1 | 1: ticks come from the external clock |
| clk_pin_dir_i | input | 1 | 1: clock pin is an output |
| matrix_en_i | input | 1 | Global matrix enable |
| led_on_i | input | 16 | Packed per-LED enable bits |
| led_level_i | input | 96 | Per-LED 8-bit brightness levels |
| imax_i | input | 3 | Full-scale current code |
| col_sel_o | output | 4 | Column switch enables, one-hot |
| row_on_o | output | 3 | Row current-sink PWM enables |
| clk_pin_o | output | 1 | Tick toggle driven to the clock pin |
| clk_pin_oe_o | output | 1 | Output enable for the clock pin |
| imax_o | output | 3 | Full-scale current code to the regulators |

## Verification
The bench models every output cycle across whole frames. It stresses level 0, level 1 and level 255 with mixed enable bits, so that a comparator using less-or-equal, or one off by one tick, lights an LED that should be dark or drops the last lit tick. Levels are rewritten in the middle of a frame: a design without the frame-boundary shadow shows the new duty in the remaining columns at once. A pattern that sets only the padding bits catches a wrong unpacking, which would light rows. The bench disables the matrix in the middle of a column and runs the external tick source with measured slot and gap lengths. A design that forgets to restart at column A, or that counts block clocks instead of external edges, then shows the wrong column or the wrong span.

// File: rtl/lms_pkg.sv
package lms_pkg;

    typedef enum logic {
        PH_BLANK = 1'b0,
        PH_DRIVE = 1'b1
    } scan_phase_e;

    // Position of the enable bit for one LED in the packed enable vector:
    // two columns share a byte, the even column in the low nibble.
    function automatic int unsigned on_bit_pos(input int unsigned col, input int unsigned row);
        return (col / 2) * 8 + (col % 2) * 4 + row;
    endfunction

endpackage

// File: rtl/lms_tick_gen.sv
module lms_tick_gen #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_i,
    input  logic sel_ext_i,
    output logic tick_o,
    output logic toggle_o
);

    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   tog;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[MSB-1:0], ext_clk_i};
        st_d.prev = st_q.sync[MSB];
        tick_o    = sel_ext_i ? (st_q.sync[MSB] & ~st_q.prev) : 1'b1;
        st_d.tog  = st_q.tog ^ tick_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign toggle_o = st_q.tog;

endmodule

// File: rtl/lms_scan_seq.sv
module lms_scan_seq
    import lms_pkg::*;
#(
    parameter int unsigned N_COLS      = 4,
    parameter int unsigned PWM_BITS    = 8,
    parameter int unsigned BLANK_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic                       tick_i,
    output logic [$clog2(N_COLS)-1:0]  col_o,
    output logic                       drive_o,
    output logic [PWM_BITS-1:0]        cnt_o,
    output logic                       load_o
);

    localparam int unsigned COL_W    = $clog2(N_COLS);
    localparam logic [COL_W-1:0]    LAST_COL  = COL_W'(N_COLS - 1);
    localparam logic [PWM_BITS-1:0] LAST_PWM  = '1;
    localparam logic [PWM_BITS-1:0] LAST_GAP  = PWM_BITS'(BLANK_TICKS - 1);

    typedef struct packed {
        logic [COL_W-1:0]    col;
        scan_phase_e         phase;
        logic [PWM_BITS-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        load_o = 1'b0;
        if (!en_i) begin
            st_d.col   = '0;
            st_d.phase = PH_BLANK;
            st_d.cnt   = '0;
            load_o     = 1'b1;
        end else if (tick_i) begin
            if (st_q.phase == PH_BLANK) begin
                if (st_q.cnt == LAST_GAP) begin
                    st_d.phase = PH_DRIVE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (st_q.cnt == LAST_PWM) begin
                st_d.phase = PH_BLANK;
                st_d.cnt   = '0;
                if (st_q.col == LAST_COL) begin
                    st_d.col = '0;
                    load_o   = 1'b1;
                end else begin
                    st_d.col = st_q.col + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{col: '0, phase: PH_BLANK, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign drive_o = (st_q.phase == PH_DRIVE);
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/lms_pixel_pwm.sv
module lms_pixel_pwm
    import lms_pkg::*;
#(
    parameter int unsigned N_COLS   = 4,
    parameter int unsigned N_ROWS   = 3,
    parameter int unsigned PWM_BITS = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 load_i,
    input  logic [((N_COLS+1)/2)*8-1:0]          on_i,
    input  logic [N_COLS*N_ROWS*PWM_BITS-1:0]    lvl_i,
    input  logic                                 en_i,
    input  logic [$clog2(N_COLS)-1:0]            col_i,
    input  logic                                 drive_i,
    input  logic [PWM_BITS-1:0]                  cnt_i,
    output logic [N_ROWS-1:0]                    row_o
);

    localparam int unsigned N_LED = N_COLS * N_ROWS;

    typedef struct packed {
        logic [N_LED-1:0]          on;
        logic [N_LED*PWM_BITS-1:0] lvl;
    } shadow_st_t;

    shadow_st_t st_d, st_q;
    logic       unused_pad;

    // Padding bits of the packed enable vector carry no function.
    assign unused_pad = ^on_i;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            for (int c = 0; c < int'(N_COLS); c++) begin
                for (int r = 0; r < int'(N_ROWS); r++) begin
                    st_d.on[c*N_ROWS + r] = on_i[on_bit_pos(c, r)];
                end
            end
            st_d.lvl = lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic [PWM_BITS-1:0] lvl_sel;
        logic                on_sel;
        always_comb begin
            lvl_sel = st_q.lvl[(int'(col_i)*N_ROWS + r)*PWM_BITS +: PWM_BITS];
            on_sel  = st_q.on[int'(col_i)*N_ROWS + r];
        end
        assign row_o[r] = en_i & drive_i & on_sel & (cnt_i < lvl_sel);
    end

endmodule

// File: rtl/led_matrix_scan.sv
module led_matrix_scan #(
    parameter int unsigned N_COLS      = 4,
    parameter int unsigned N_ROWS      = 3,
    parameter int unsigned PWM_BITS    = 8,
    parameter int unsigned BLANK_TICKS = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IMAX_W      = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ext_clk_i,
    input  logic                               clk_src_ext_i,
    input  logic                               clk_pin_dir_i,
    input  logic                               matrix_en_i,
    input  logic [((N_COLS+1)/2)*8-1:0]        led_on_i,
    input  logic [N_COLS*N_ROWS*PWM_BITS-1:0]  led_level_i,
    input  logic [IMAX_W-1:0]                  imax_i,
    output logic [N_COLS-1:0]                  col_sel_o,
    output logic [N_ROWS-1:0]                  row_on_o,
    output logic                               clk_pin_o,
    output logic                               clk_pin_oe_o,
    output logic [IMAX_W-1:0]                  imax_o
);

    localparam int unsigned COL_W = $clog2(N_COLS);

    logic                tick;
    logic [COL_W-1:0]    scan_col;
    logic                scan_drive;
    logic [PWM_BITS-1:0] scan_cnt;
    logic                shadow_load;

    lms_tick_gen #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_clk_i),
        .sel_ext_i (clk_src_ext_i),
        .tick_o    (tick),
        .toggle_o  (clk_pin_o)
    );

    lms_scan_seq #(
        .N_COLS      (N_COLS),
        .PWM_BITS    (PWM_BITS),
        .BLANK_TICKS (BLANK_TICKS)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (matrix_en_i),
        .tick_i  (tick),
        .col_o   (scan_col),
        .drive_o (scan_drive),
        .cnt_o   (scan_cnt),
        .load_o  (shadow_load)
    );

    lms_pixel_pwm #(
        .N_COLS   (N_COLS),
        .N_ROWS   (N_ROWS),
        .PWM_BITS (PWM_BITS)
    ) i_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (shadow_load),
        .on_i    (led_on_i),
        .lvl_i   (led_level_i),
        .en_i    (matrix_en_i),
        .col_i   (scan_col),
        .drive_i (scan_drive),
        .cnt_i   (scan_cnt),
        .row_o   (row_on_o)
    );

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        assign col_sel_o[c] = matrix_en_i & scan_drive & (scan_col == COL_W'(c));
    end

    assign clk_pin_oe_o = clk_pin_dir_i & ~clk_src_ext_i;
    assign imax_o       = imax_i;

endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
    parameter int unsigned N_COLS = 4,
    parameter int unsigned N_ROWS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              matrix_en_i,
    input logic [N_COLS-1:0] col_sel_o,
    input logic [N_ROWS-1:0] row_on_o
);

    a_r2_one_column: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel_o));

    a_r10_rows_need_column: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_on_o) |-> (|col_sel_o));

    a_r1_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !matrix_en_i |-> (col_sel_o == '0 && row_on_o == '0));

    a_r4_gap_between_columns: assert property (@(posedge clk) disable iff (!rst_n)
        ((|col_sel_o) && (|$past(col_sel_o))) |-> (col_sel_o == $past(col_sel_o)));

endmodule

bind led_matrix_scan lms_checker #(
    .N_COLS (N_COLS),
    .N_ROWS (N_ROWS)
) i_lms_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .matrix_en_i (matrix_en_i),
    .col_sel_o   (col_sel_o),
    .row_on_o    (row_on_o)
);

// File: tb/test_led_matrix_scan.sv
`timescale 1ns/1ps
module test_led_matrix_scan;

    localparam int NC = 4;
    localparam int NR = 3;
    localparam int GAP = 2;
    localparam int SLOT = GAP + 256;
    localparam int FRAME = NC * SLOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic        src_ext = 1'b0;
    logic        pin_dir = 1'b0;
    logic        en = 1'b0;
    logic [15:0] led_on = '0;
    logic [95:0] led_lvl = '0;
    logic [2:0]  imax = '0;
    logic [3:0]  col_sel;
    logic [2:0]  row_on;
    logic        pin_o, pin_oe;
    logic [2:0]  imax_o;

    int checks = 0;
    int errors = 0;
    bit ext_run = 0;

    typedef struct packed {
        logic [3:0] col;
        logic [2:0] row;
        logic [3:0] rq_col;
        logic [3:0] rq_row;
    } exp_t;

    exp_t       sb_q[$];
    logic       snap_on [NC*NR];
    logic [7:0] snap_lvl[NC*NR];

    always #2.5 clk = ~clk;

    led_matrix_scan i_led_matrix_scan (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_clk_i     (ext_clk),
        .clk_src_ext_i (src_ext),
        .clk_pin_dir_i (pin_dir),
        .matrix_en_i   (en),
        .led_on_i      (led_on),
        .led_level_i   (led_lvl),
        .imax_i        (imax),
        .col_sel_o     (col_sel),
        .row_on_o      (row_on),
        .clk_pin_o     (pin_o),
        .clk_pin_oe_o  (pin_oe),
        .imax_o        (imax_o)
    );

    task automatic check(input bit ok, input int rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // R5: enable bit of column c, row r sits at byte c/2, nibble c%2, bit r.
    task automatic take_snapshot();
        for (int c = 0; c < NC; c++) begin
            for (int r = 0; r < NR; r++) begin
                snap_on[c*NR+r]  = led_on[(c/2)*8 + (c%2)*4 + r];
                snap_lvl[c*NR+r] = led_lvl[(c*NR+r)*8 +: 8];
            end
        end
    endtask

    // Driver: pushes the expected outputs after each clock edge since enable.
    task automatic play(input int cycles, input int change_at, input logic [15:0] new_on,
                        input logic [95:0] new_lvl, input int row_tag, input int col_tag);
        take_snapshot();
        for (int n = 1; n <= cycles; n++) begin
            exp_t e;
            int s, c, w;
            @(posedge clk);
            #1;
            s = n % FRAME;
            if (s == 0) take_snapshot();
            c = s / SLOT;
            w = s % SLOT;
            e.col = '0;
            e.row = '0;
            e.rq_col = 4'(col_tag);
            e.rq_row = (w < GAP) ? 4'd4 : ((change_at > 0 && n > change_at) ? 4'd6 : 4'(row_tag));
            if (w >= GAP) begin
                e.col = 4'b0001 << c;
                for (int r = 0; r < NR; r++)
                    e.row[r] = snap_on[c*NR+r] && ((w - GAP) < int'(snap_lvl[c*NR+r]));
            end
            sb_q.push_back(e);
            if (n == change_at) begin
                @(negedge clk);
                led_on  = new_on;
                led_lvl = new_lvl;
            end
        end
        wait (sb_q.size() == 0);
    endtask

    // Monitor: compares outputs against the queue between clock edges.
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(col_sel == e.col, int'(e.rq_col), "column select", col_sel, e.col);
            check(row_on == e.row, int'(e.rq_row), "row enables", row_on, e.row);
        end
    end

    initial begin
        #1;
        forever begin
            #10;
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    function automatic logic [95:0] lvls(input logic [7:0] v [12]);
        logic [95:0] x;
        for (int i = 0; i < 12; i++) x[i*8 +: 8] = v[i];
        return x;
    endfunction

    initial begin : main
        logic [7:0] la [12];
        logic [7:0] lb [12];
        logic [95:0] va, vb;
        logic [3:0] held;
        int span;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, matrix off
        check(col_sel == 4'b0, 1, "reset columns", col_sel, 0);
        check(row_on == 3'b0, 1, "reset rows", row_on, 0);
        check(pin_oe == 1'b0, 8, "reset pin direction", pin_oe, 0);

        // R9: current code pass-through
        imax = 3'b101;
        #1 check(imax_o == 3'b101, 9, "imax", imax_o, 3'b101);
        imax = 3'b010;
        #1 check(imax_o == 3'b010, 9, "imax", imax_o, 3'b010);

        // R8: pin driven with the internal source, toggling every tick
        @(negedge clk);
        pin_dir = 1'b1;
        #1 check(pin_oe == 1'b1, 8, "pin output enable", pin_oe, 1);
        begin
            logic p0;
            p0 = pin_o;
            @(negedge clk);
            check(pin_o == ~p0, 8, "pin toggle", pin_o, ~p0);
            @(negedge clk);
            check(pin_o == p0, 8, "pin toggle", pin_o, p0);
        end

        // R3 R5 R6: mixed levels, padding bits set, mid-frame rewrite
        la = '{8'd0, 8'd255, 8'd7, 8'd1, 8'd100, 8'd255, 8'd200, 8'd128, 8'd64, 8'd255, 8'd2, 8'd128};
        lb = '{8'd50, 8'd1, 8'd255, 8'd0, 8'd30, 8'd9, 8'd255, 8'd255, 8'd1, 8'd17, 8'd240, 8'd3};
        va = lvls(la);
        vb = lvls(lb);
        led_on  = 16'hFE_DB;
        led_lvl = va;
        @(negedge clk);
        en = 1'b1;
        play(3*FRAME + 600, FRAME + 300, 16'h7F_B6, vb, 3, 2);

        // R1: disable inside a lit column
        @(negedge clk);
        en = 1'b0;
        #1;
        check(col_sel == 4'b0, 1, "columns after disable", col_sel, 0);
        check(row_on == 3'b0, 1, "rows after disable", row_on, 0);
        repeat (5) @(negedge clk);
        check(col_sel == 4'b0, 1, "columns while off", col_sel, 0);

        // R5: only padding bits set, all levels full; R1: restart at column A
        led_on  = 16'h8888;
        led_lvl = '1;
        @(negedge clk);
        en = 1'b1;
        play(FRAME + 10, 0, '0, '0, 5, 1);

        // R7 R8: external tick source, one tick per 4 clock cycles
        @(negedge clk);
        en = 1'b0;
        led_on = 16'h7777;
        src_ext = 1'b1;
        ext_run = 1'b1;
        #1 check(pin_oe == 1'b0, 8, "pin released with external source", pin_oe, 0);
        repeat (10) @(negedge clk);
        en = 1'b1;
        while (col_sel != 4'b0001) @(negedge clk);
        span = 0;
        while (col_sel == 4'b0001) begin span++; @(negedge clk); end
        check(span == 1024, 7, "column A span in clocks", span, 1024);
        span = 0;
        while (col_sel == 4'b0000) begin span++; @(negedge clk); end
        check(span == 8, 4, "gap span in clocks", span, 8);
        check(col_sel == 4'b0010, 2, "column after A", col_sel, 4'b0010);

        // R7: static external clock freezes the scan
        ext_run = 1'b0;
        repeat (20) @(negedge clk);
        held = col_sel;
        span = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (col_sel != held) span++;
        end
        check(span == 0, 7, "scan frozen without external edges", span, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule